// File: doc/BRIEF.md
# Clock root frequency calculator

This block works out, in hertz, the frequency of a requested clock root from the current clock-tree control fields. A query code and a start strobe begin a calculation. The block then walks the tree: a fixed 24 MHz reference oscillator, a system PLL with a selectable multiplier, two fractional-divider outputs, a four-way pre-peripheral selector, an alternate peripheral branch with its own post-divider, and the cascaded bus and peripheral post-dividers. A 32-bit result, a one-cycle done strobe and an error flag report the outcome.

All divisions go through one shared restoring divider that produces one quotient bit per cycle. Intermediate values are 64 bits wide, so a PLL frequency times 18 never overflows. Every control field and the query code are captured when a start is accepted, so the control inputs may change while a calculation runs. A query with no divisions finishes in two cycles. The longest query takes four divisions of about 65 cycles each.

Top module: `clk_freq_calc`

## Requirements
- R1: After reset, freq, done, err and busy are all 0.
- R2: With pre_sel 0 and periph_alt 0, the peripheral root is the system PLL: 528,000,000 Hz when pll_mul22 is 1 and 480,000,000 Hz when it is 0.
- R3: pre_sel 1 gives PLL*18/pfd2_frac and pre_sel 2 gives PLL*18/pfd0_frac, rounded down. The frac field of the output that is not selected has no effect on the result or on err.
- R4: pre_sel 3 gives floor(PLL*18/pfd2_frac/2).
- R5: If the selected frac field is 0, that stage yields 0 and err is 1 in the result.
- R6: With periph_alt 1, the root is the alternate source divided by (1 + alt_div), rounded down. alt_sel 0 is the 480,000,000 Hz USB PLL, alt_sel 1 is the 24,000,000 Hz oscillator and alt_sel 2 is the bypass clock, which is 0 with no error.
- R7: alt_sel 3 is reserved. It yields 0 and sets err whenever the alternate branch is evaluated.
- R8: The bus clock is root/(1 + ahb_div) and IPG is bus/(1 + ipg_div), each rounded down in turn.
- R9: Query 2 ("IPG high") returns (per_osc ? 24,000,000 : IPG)/(1 + per_div). When per_osc is 1, the peripheral tree is not evaluated and its faults do not set err.
- R10: The query codes are 0 none (result 0), 1 IPG, 3 the 32,768 Hz constant, 4 the 24,000,000 Hz reference and 5 the reference divided by 8 (3,000,000 Hz). Codes 6 and 7 return 0 with err set. For codes 0 and 3 to 7, done is high in the second cycle after the accepting edge.
- R11: A start is accepted only while busy is 0, and busy is 1 from the cycle after acceptance. A start while busy is ignored. All fields and the query are captured at acceptance.
- R12: done is high for exactly one cycle, with busy 0. freq and err change only in that cycle and hold until the next done. A start given in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (taken when idle) |
| query | input | 3 | Requested clock code |
| pll_mul22 | input | 1 | System PLL multiplier: 1 means x22, 0 means x20 |
| pfd0_frac | input | FRAC_W | Fraction field of fractional output 0 |
| pfd2_frac | input | FRAC_W | Fraction field of fractional output 2 |
| pre_sel | input | 2 | Pre-peripheral source select |
| alt_sel | input | 2 | Alternate peripheral source select |
| alt_div | input | ALT_DIV_W | Alternate branch post-divider field |
| periph_alt | input | 1 | Peripheral root: 0 means pre-peripheral, 1 means alternate |
| ahb_div | input | AHB_DIV_W | Bus clock post-divider field |
| ipg_div | input | IPG_DIV_W | IPG post-divider field |
| per_osc | input | 1 | Per-clock source: 0 means IPG, 1 means oscillator |
| per_div | input | PER_DIV_W | Per-clock post-divider field |
| freq | output | 32 | Result in Hz |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Error flag of the last result |
| busy | output | 1 | Calculation in progress |

## Verification
The completion of one calculation and the acceptance of the next can fall in the same cycle. This is because done is raised with busy low, and a start in that cycle must be taken. The bench waits for done and drives a new start and query in that very cycle. It then checks that the next cycle shows busy high and done low, that the previous frequency is still on freq, and that the second calculation later delivers its own value. A second case drives a start with a different query while a long calculation runs. That case checks that exactly one done follows and that it carries the first query's result.

// File: rtl/clk_freq_pkg.sv
package clk_freq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROOT = 3'd1,
        ST_AHB  = 3'd2,
        ST_IPG  = 3'd3,
        ST_PER  = 3'd4,
        ST_FIN  = 3'd5
    } calc_step_e;

    typedef enum logic [2:0] {
        Q_NONE   = 3'd0,
        Q_IPG    = 3'd1,
        Q_IPG_HI = 3'd2,
        Q_SLOW   = 3'd3,
        Q_REF    = 3'd4,
        Q_REF8   = 3'd5
    } calc_query_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clk_freq_divider.sv
// Restoring divider: one quotient bit per cycle, NUM_W cycles per division.
module clk_freq_divider #(
    parameter int NUM_W = 64,
    parameter int DEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             valid
);
    localparam int CNT_W = $clog2(NUM_W);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
        logic             valid;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [DEN_W:0] rem_sh;
    logic [DEN_W:0] rem_sub;
    logic           fits;

    always_comb begin
        s_d     = s_q;
        s_d.valid = 1'b0;
        rem_sh  = {s_q.rem, s_q.quo[NUM_W-1]};
        fits    = (rem_sh >= {1'b0, s_q.den});
        rem_sub = rem_sh - {1'b0, s_q.den};
        if (go) begin
            s_d.run = 1'b1;
            s_d.cnt = '0;
            s_d.quo = num;
            s_d.rem = '0;
            s_d.den = den;
        end else if (s_q.run) begin
            s_d.rem = fits ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
            s_d.quo = {s_q.quo[NUM_W-2:0], fits};
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == CNT_W'(NUM_W - 1)) begin
                s_d.run   = 1'b0;
                s_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign quo   = s_q.quo;
    assign valid = s_q.valid;
endmodule

// File: rtl/clk_freq_src.sv
// Operand selection for each division step of the clock-tree walk.
module clk_freq_src
    import clk_freq_pkg::*;
#(
    parameter int REF_HZ    = 24000000,
    parameter int NUM_W     = 64,
    parameter int DEN_W     = 7,
    parameter int FRAC_W    = 6,
    parameter int ALT_DIV_W = 3,
    parameter int AHB_DIV_W = 3,
    parameter int IPG_DIV_W = 2,
    parameter int PER_DIV_W = 6
) (
    input  calc_step_e           step,
    input  logic                 mul22,
    input  logic [FRAC_W-1:0]    frac0,
    input  logic [FRAC_W-1:0]    frac2,
    input  logic [1:0]           pre_sel,
    input  logic [1:0]           alt_sel,
    input  logic [ALT_DIV_W-1:0] alt_div,
    input  logic                 use_alt,
    input  logic [AHB_DIV_W-1:0] ahb_div,
    input  logic [IPG_DIV_W-1:0] ipg_div,
    input  logic                 per_osc,
    input  logic [PER_DIV_W-1:0] per_div,
    input  logic [NUM_W-1:0]     acc,
    output logic [NUM_W-1:0]     num,
    output logic [DEN_W-1:0]     den,
    output logic                 src_err
);
    localparam logic [NUM_W-1:0] OSC_F   = NUM_W'(REF_HZ);
    localparam logic [NUM_W-1:0] PLL_X20 = OSC_F * NUM_W'(20);
    localparam logic [NUM_W-1:0] PLL_X22 = OSC_F * NUM_W'(22);
    localparam logic [NUM_W-1:0] PFD_MUL = NUM_W'(18);

    logic [NUM_W-1:0] pll_f;
    logic [NUM_W-1:0] pfd_num;

    assign pll_f   = mul22 ? PLL_X22 : PLL_X20;
    assign pfd_num = pll_f * PFD_MUL;

    always_comb begin
        num     = acc;
        den     = DEN_W'(1);
        src_err = 1'b0;
        case (step)
            ST_ROOT: begin
                if (!use_alt) begin
                    case (pre_sel)
                        2'd0: begin num = pll_f;   den = DEN_W'(1); end
                        2'd1: begin num = pfd_num; den = DEN_W'(frac2); end
                        2'd2: begin num = pfd_num; den = DEN_W'(frac0); end
                        default: begin
                            // floor(floor(a/b)/2) equals floor(a/(2b))
                            num = pfd_num;
                            den = DEN_W'(frac2) << 1;
                        end
                    endcase
                end else begin
                    den = DEN_W'(alt_div) + DEN_W'(1);
                    case (alt_sel)
                        2'd0:    num = PLL_X20;
                        2'd1:    num = OSC_F;
                        2'd2:    num = '0;
                        default: begin num = '0; src_err = 1'b1; end
                    endcase
                end
            end
            ST_AHB: den = DEN_W'(ahb_div) + DEN_W'(1);
            ST_IPG: den = DEN_W'(ipg_div) + DEN_W'(1);
            ST_PER: begin
                num = per_osc ? OSC_F : acc;
                den = DEN_W'(per_div) + DEN_W'(1);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/clk_freq_calc.sv
module clk_freq_calc
    import clk_freq_pkg::*;
#(
    parameter int REF_HZ    = 24000000,
    parameter int SLOW_HZ   = 32768,
    parameter int FREQ_W    = 32,
    parameter int NUM_W     = 64,
    parameter int FRAC_W    = 6,
    parameter int ALT_DIV_W = 3,
    parameter int AHB_DIV_W = 3,
    parameter int IPG_DIV_W = 2,
    parameter int PER_DIV_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           query,
    input  logic                 pll_mul22,
    input  logic [FRAC_W-1:0]    pfd0_frac,
    input  logic [FRAC_W-1:0]    pfd2_frac,
    input  logic [1:0]           pre_sel,
    input  logic [1:0]           alt_sel,
    input  logic [ALT_DIV_W-1:0] alt_div,
    input  logic                 periph_alt,
    input  logic [AHB_DIV_W-1:0] ahb_div,
    input  logic [IPG_DIV_W-1:0] ipg_div,
    input  logic                 per_osc,
    input  logic [PER_DIV_W-1:0] per_div,
    output logic [FREQ_W-1:0]    freq,
    output logic                 done,
    output logic                 err,
    output logic                 busy
);
    localparam int DEN_W = max2(FRAC_W, max2(ALT_DIV_W, max2(AHB_DIV_W,
                           max2(IPG_DIV_W, PER_DIV_W)))) + 1;

    typedef struct packed {
        calc_step_e           step;
        logic                 waiting;
        logic [2:0]           qry;
        logic                 mul22;
        logic [FRAC_W-1:0]    frac0;
        logic [FRAC_W-1:0]    frac2;
        logic [1:0]           pre_sel;
        logic [1:0]           alt_sel;
        logic [ALT_DIV_W-1:0] alt_div;
        logic                 use_alt;
        logic [AHB_DIV_W-1:0] ahb_div;
        logic [IPG_DIV_W-1:0] ipg_div;
        logic                 per_osc;
        logic [PER_DIV_W-1:0] per_div;
        logic [NUM_W-1:0]     acc;
        logic                 err_acc;
        logic [FREQ_W-1:0]    freq;
        logic                 err;
        logic                 done;
    } calc_state_t;

    calc_state_t s_d, s_q;

    logic [NUM_W-1:0] src_num;
    logic [DEN_W-1:0] src_den;
    logic             src_err;
    logic             div_go;
    logic [NUM_W-1:0] div_quo;
    logic             div_valid;
    calc_step_e       step_next;

    clk_freq_src #(
        .REF_HZ(REF_HZ), .NUM_W(NUM_W), .DEN_W(DEN_W), .FRAC_W(FRAC_W),
        .ALT_DIV_W(ALT_DIV_W), .AHB_DIV_W(AHB_DIV_W),
        .IPG_DIV_W(IPG_DIV_W), .PER_DIV_W(PER_DIV_W)
    ) u_src (
        .step    (s_q.step),
        .mul22   (s_q.mul22),
        .frac0   (s_q.frac0),
        .frac2   (s_q.frac2),
        .pre_sel (s_q.pre_sel),
        .alt_sel (s_q.alt_sel),
        .alt_div (s_q.alt_div),
        .use_alt (s_q.use_alt),
        .ahb_div (s_q.ahb_div),
        .ipg_div (s_q.ipg_div),
        .per_osc (s_q.per_osc),
        .per_div (s_q.per_div),
        .acc     (s_q.acc),
        .num     (src_num),
        .den     (src_den),
        .src_err (src_err)
    );

    clk_freq_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (src_num),
        .den   (src_den),
        .quo   (div_quo),
        .valid (div_valid)
    );

    always_comb begin
        case (s_q.step)
            ST_ROOT: step_next = ST_AHB;
            ST_AHB:  step_next = ST_IPG;
            ST_IPG:  step_next = (s_q.qry == Q_IPG_HI) ? ST_PER : ST_FIN;
            default: step_next = ST_FIN;
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        div_go   = 1'b0;
        case (s_q.step)
            ST_IDLE: begin
                if (start) begin
                    s_d.qry     = query;
                    s_d.mul22   = pll_mul22;
                    s_d.frac0   = pfd0_frac;
                    s_d.frac2   = pfd2_frac;
                    s_d.pre_sel = pre_sel;
                    s_d.alt_sel = alt_sel;
                    s_d.alt_div = alt_div;
                    s_d.use_alt = periph_alt;
                    s_d.ahb_div = ahb_div;
                    s_d.ipg_div = ipg_div;
                    s_d.per_osc = per_osc;
                    s_d.per_div = per_div;
                    s_d.acc     = '0;
                    s_d.err_acc = 1'b0;
                    s_d.waiting = 1'b0;
                    case (query)
                        Q_IPG:    s_d.step = ST_ROOT;
                        Q_IPG_HI: s_d.step = per_osc ? ST_PER : ST_ROOT;
                        Q_NONE:   s_d.step = ST_FIN;
                        Q_SLOW: begin
                            s_d.acc  = NUM_W'(SLOW_HZ);
                            s_d.step = ST_FIN;
                        end
                        Q_REF: begin
                            s_d.acc  = NUM_W'(REF_HZ);
                            s_d.step = ST_FIN;
                        end
                        Q_REF8: begin
                            s_d.acc  = NUM_W'(REF_HZ / 8);
                            s_d.step = ST_FIN;
                        end
                        default: begin
                            s_d.err_acc = 1'b1;
                            s_d.step    = ST_FIN;
                        end
                    endcase
                end
            end
            ST_FIN: begin
                s_d.freq = s_q.acc[FREQ_W-1:0];
                s_d.err  = s_q.err_acc;
                s_d.done = 1'b1;
                s_d.step = ST_IDLE;
            end
            default: begin
                if (!s_q.waiting) begin
                    if (src_err) s_d.err_acc = 1'b1;
                    if (src_den == '0) begin
                        s_d.acc     = '0;
                        s_d.err_acc = 1'b1;
                        s_d.step    = step_next;
                    end else begin
                        div_go      = 1'b1;
                        s_d.waiting = 1'b1;
                    end
                end else if (div_valid) begin
                    s_d.acc     = div_quo;
                    s_d.waiting = 1'b0;
                    s_d.step    = step_next;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign freq = s_q.freq;
    assign done = s_q.done;
    assign err  = s_q.err;
    assign busy = (s_q.step != ST_IDLE);
endmodule

// File: rtl/clk_freq_calc_chk.sv
module clk_freq_calc_chk #(
    parameter int REF_HZ = 24000000,
    parameter int FREQ_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        query,
    input logic [FREQ_W-1:0] freq,
    input logic              done,
    input logic              err,
    input logic              busy
);
    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_freq_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(freq));

    assert_err_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(err));

    assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_ref_const_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && query == 3'd4) |-> ##2 (done && !err && freq == FREQ_W'(REF_HZ)));

    assert_bad_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && query >= 3'd6) |-> ##2 (done && err && freq == '0));
endmodule

bind clk_freq_calc clk_freq_calc_chk #(.REF_HZ(REF_HZ), .FREQ_W(FREQ_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .query (query),
    .freq  (freq),
    .done  (done),
    .err   (err),
    .busy  (busy)
);

// File: tb/clk_freq_calc_bench.sv
module clk_freq_calc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  query = '0;
    logic        pll_mul22 = 1'b1;
    logic [5:0]  pfd0_frac = 6'd27;
    logic [5:0]  pfd2_frac = 6'd24;
    logic [1:0]  pre_sel = '0;
    logic [1:0]  alt_sel = '0;
    logic [2:0]  alt_div = '0;
    logic        periph_alt = 1'b0;
    logic [2:0]  ahb_div = '0;
    logic [1:0]  ipg_div = '0;
    logic        per_osc = 1'b0;
    logic [5:0]  per_div = '0;
    logic [31:0] freq;
    logic        done, err, busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    clk_freq_calc u_clk_freq_calc (
        .clk(clk), .rst_n(rst_n), .start(start), .query(query),
        .pll_mul22(pll_mul22), .pfd0_frac(pfd0_frac), .pfd2_frac(pfd2_frac),
        .pre_sel(pre_sel), .alt_sel(alt_sel), .alt_div(alt_div),
        .periph_alt(periph_alt), .ahb_div(ahb_div), .ipg_div(ipg_div),
        .per_osc(per_osc), .per_div(per_div),
        .freq(freq), .done(done), .err(err), .busy(busy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic m22, input logic [5:0] f0, input logic [5:0] f2,
                           input logic [1:0] ps, input logic alt, input logic [1:0] as,
                           input logic [2:0] ad, input logic [2:0] hd, input logic [1:0] id,
                           input logic po, input logic [5:0] pd);
        pll_mul22 = m22; pfd0_frac = f0; pfd2_frac = f2; pre_sel = ps;
        periph_alt = alt; alt_sel = as; alt_div = ad; ahb_div = hd;
        ipg_div = id; per_osc = po; per_div = pd;
    endtask

    // Ends at the falling edge in which done is high.
    task automatic run_query(input logic [2:0] q, input logic [31:0] exp_f,
                             input logic exp_e, input string tag);
        @(negedge clk);
        start = 1'b1;
        query = q;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
        check({tag, " done"}, {31'd0, done}, 32'd1);
        check({tag, " freq"}, freq, exp_f);
        check({tag, " err"}, {31'd0, err}, {31'd0, exp_e});
    endtask

    task automatic t_reset;
        check("R1 freq", freq, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 err", {31'd0, err}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_pll_direct;
        set_cfg(1, 27, 24, 0, 0, 0, 0, 0, 1, 0, 0);
        run_query(3'd1, 32'd264000000, 0, "R2 pll x22");
        set_cfg(0, 27, 24, 0, 0, 0, 0, 0, 0, 0, 0);
        run_query(3'd1, 32'd480000000, 0, "R2 pll x20");
    endtask

    task automatic t_pfd;
        set_cfg(1, 27, 24, 1, 0, 0, 0, 2, 1, 0, 0);
        run_query(3'd1, 32'd66000000, 0, "R3 pfd2");
        set_cfg(1, 27, 0, 2, 0, 0, 0, 3, 1, 0, 0);
        run_query(3'd1, 32'd44000000, 0, "R3 pfd0 other frac zero");
    endtask

    task automatic t_pfd_half;
        set_cfg(0, 27, 24, 3, 0, 0, 0, 0, 0, 0, 0);
        run_query(3'd1, 32'd180000000, 0, "R4 pfd2 half");
    endtask

    task automatic t_frac_zero;
        set_cfg(1, 27, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        run_query(3'd1, 32'd0, 1, "R5 frac zero");
    endtask

    task automatic t_alt;
        set_cfg(1, 27, 24, 0, 1, 0, 3, 1, 0, 0, 0);
        run_query(3'd1, 32'd60000000, 0, "R6 alt usb");
        set_cfg(1, 27, 24, 0, 1, 1, 0, 0, 0, 0, 0);
        run_query(3'd1, 32'd24000000, 0, "R6 alt osc");
        set_cfg(1, 27, 24, 0, 1, 2, 0, 0, 0, 0, 0);
        run_query(3'd1, 32'd0, 0, "R6 alt bypass");
    endtask

    task automatic t_alt_reserved;
        set_cfg(1, 27, 24, 0, 1, 3, 0, 0, 0, 0, 0);
        run_query(3'd1, 32'd0, 1, "R7 alt reserved");
    endtask

    task automatic t_cascade;
        set_cfg(0, 27, 24, 0, 0, 0, 0, 6, 0, 0, 0);
        run_query(3'd1, 32'd68571428, 0, "R8 floor cascade");
        set_cfg(1, 27, 24, 0, 0, 0, 0, 3, 3, 0, 0);
        run_query(3'd1, 32'd33000000, 0, "R8 ahb ipg");
    endtask

    task automatic t_per;
        set_cfg(1, 27, 24, 0, 0, 0, 0, 0, 1, 0, 3);
        run_query(3'd2, 32'd66000000, 0, "R9 per from ipg");
        set_cfg(1, 27, 24, 0, 1, 3, 0, 0, 0, 1, 5);
        run_query(3'd2, 32'd4000000, 0, "R9 per from osc skips tree");
    endtask

    task automatic t_consts;
        run_query(3'd0, 32'd0, 0, "R10 none");
        run_query(3'd3, 32'd32768, 0, "R10 slow");
        run_query(3'd4, 32'd24000000, 0, "R10 ref");
        run_query(3'd5, 32'd3000000, 0, "R10 ref div8");
        run_query(3'd6, 32'd0, 1, "R10 code 6");
        run_query(3'd7, 32'd0, 1, "R10 code 7");
    endtask

    task automatic t_busy_ignore;
        set_cfg(1, 27, 24, 0, 0, 0, 0, 0, 1, 0, 0);
        @(negedge clk);
        start = 1'b1;
        query = 3'd1;
        @(negedge clk);
        start = 1'b0;
        check("R11 busy after accept", {31'd0, busy}, 32'd1);
        repeat (5) @(negedge clk);
        ipg_div = 2'd0;
        pll_mul22 = 1'b0;
        start = 1'b1;
        query = 3'd4;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
        check("R11 ignored start freq", freq, 32'd264000000);
        check("R11 ignored start err", {31'd0, err}, 32'd0);
        @(negedge clk);
        check("R12 single done", {31'd0, done}, 32'd0);
        repeat (3) @(negedge clk);
        check("R11 no second done", {31'd0, done}, 32'd0);
        check("R12 freq held", freq, 32'd264000000);
    endtask

    task automatic t_back_to_back;
        run_query(3'd4, 32'd24000000, 0, "R12 first");
        start = 1'b1;
        query = 3'd5;
        @(negedge clk);
        start = 1'b0;
        check("R12 start in done cycle taken", {31'd0, busy}, 32'd1);
        check("R12 done dropped", {31'd0, done}, 32'd0);
        check("R12 old freq kept", freq, 32'd24000000);
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
        check("R12 second result", freq, 32'd3000000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_pll_direct;
        t_pfd;
        t_pfd_half;
        t_frac_zero;
        t_alt;
        t_alt_reserved;
        t_cascade;
        t_per;
        t_consts;
        t_busy_ignore;
        t_back_to_back;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule